// File: doc/BRIEF.md
# Selectable-Source Integer Clock Divider

This block derives an output clock from one of eleven auxiliary source clocks. A plain combinational multiplexer picks the source, so the selection should change only while the generator is stopped. The selected clock then drives an integer divider. Control pins set the divisor, start and stop the generator, stop it at once without a clock edge, delay the start by a programmable number of source cycles, slip the output phase by one source cycle on demand, and pull the high time of odd divisors toward half the period. A status pin tells whether the divider is currently producing output.

Start and stop requests pass through a two-stage synchronizer on the selected clock. Then they pass through the phase delay, which is captured while the divider is idle. A stop request lets the current output period finish and leaves the output low. The immediate stop is asynchronous and clears every register of the generator while it is held. The divisor and duty-correction settings can change while the clock runs. They are loaded at the next period boundary.

Top module: `clkgen_top`

## Requirements
- R1: `src_sel` values 0 to 10 route `src_clk[src_sel]` into the divider, so the output period is the divisor times the period of that source.
- R2: `src_sel` values 11 to 15 select no source: the output stays low and `running` stays low even while `run_en` is high.
- R3: For a divisor N of at least 2 with duty correction off, each output period lasts N source cycles and the output is high for floor(N/2) of them, rising on a source rising edge. A divisor of 0 or 1 passes the source through, high for half a source cycle in every cycle.
- R4: With `duty_fix` high and an odd N of at least 3, the output is high for (N-1)/2 source cycles plus one half cycle. For even N the setting has no effect.
- R5: After `run_en` rises between source edges, `running` and the output both go high right after the (3+P)th source rising edge, where P is the value of `en_phase` (0 to 3) captured while the generator was stopped.
- R6: When `run_en` falls, the output period in progress completes with its full high time. After that the output stays low with no further rising edge, and `running` goes low.
- R7: While `kill` is high, the output and `running` are low at once, without waiting for a source edge. After `kill` is released with `run_en` still high, the generator starts again.
- R8: Each transition of `nudge`, rising or falling, while running with N of at least 4 lengthens exactly one output period by one source cycle. Across the two periods that follow the transition, the total is 2N+1 source cycles.
- R9: A divisor written while running does not alter the period in progress. It takes effect from the next period.
- R10: During reset (`rst_n` low) the output and `running` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 11 | Auxiliary source clocks, bit i is source i |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 4 | Source select; values above 10 select nothing |
| div_ratio | input | 8 | Integer divisor; 0 is treated as 1 |
| run_en | input | 1 | Clean start/stop request |
| kill | input | 1 | Asynchronous immediate stop, active high |
| en_phase | input | 2 | Start delay in source cycles, taken while stopped |
| nudge | input | 1 | Each transition slips the output by one source cycle |
| duty_fix | input | 1 | Duty correction for odd divisors |
| clk_out | output | 1 | Divided output clock |
| running | output | 1 | High while the divider is producing output |

## Verification
The situation hardest to reach from the pins is a control transition that lands at a known point inside an output period: a phase slip or a stop request that must be seen before the period boundary, or a divisor change that must not be. The stimulus waits for a rising edge of `clk_out` and changes the control one nanosecond later. Because of the synchronizer latency, the change then reaches the counter a fixed number of source edges before the wrap. Seeded random runs then sweep source, divisor and duty correction, and each run compares the measured high time and period against values computed from the source period.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;
  localparam int unsigned CG_NUM_SRC  = 11;
  localparam int unsigned CG_SEL_W    = 4;
  localparam int unsigned CG_DIV_W    = 8;
  localparam int unsigned CG_PH_W     = 2;
  localparam int unsigned CG_SYNC_LEN = 2;

  typedef enum logic {
    CG_IDLE = 1'b0,
    CG_RUN  = 1'b1
  } cg_state_e;
endpackage

// File: rtl/clkgen_src_mux.sv
`timescale 1ns/1ps
module clkgen_src_mux #(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned SEL_W   = 4
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               clk_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_leg
    assign hit[gi] = src_i[gi] & (sel_i == SEL_W'(gi));
  end

  assign clk_o = |hit;
endmodule

// File: rtl/clkgen_sync.sv
`timescale 1ns/1ps
module clkgen_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/clkgen_en_delay.sv
`timescale 1ns/1ps
module clkgen_en_delay #(
  parameter int unsigned PH_W = 2
) (
  input  logic            clk,
  input  logic            clr_n,
  input  logic            en_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic            busy_i,
  output logic            en_o
);
  localparam int unsigned DEPTH = (1 << PH_W) - 1;

  logic [PH_W-1:0]  ph_q;
  logic [DEPTH-1:0] dly;
  logic [DEPTH:0]   taps;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      ph_q <= '0;
      dly  <= '0;
    end else begin
      if (!busy_i) ph_q <= phase_i;
      dly[0] <= en_i;
      for (int i = 1; i < DEPTH; i++) dly[i] <= dly[i-1];
    end
  end

  assign taps = {dly, en_i};
  assign en_o = taps[ph_q];
endmodule

// File: rtl/clkgen_divider.sv
`timescale 1ns/1ps
module clkgen_divider
  import clkgen_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             en_i,
  input  logic             nudge_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             dc_i,
  output logic             active_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] div_o,
  output logic             clk_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  cg_state_e        state;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_q;
  logic             dc_q;
  logic             out_q;
  logic             out_n;
  logic             gate_n;

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] cnt_nx;
  logic [DIV_W-1:0] half;
  logic             wrap;
  logic             pass;

  assign div_eff = (div_i == '0) ? ONE : div_i;
  assign cnt_nx  = cnt + ONE;
  assign half    = div_q >> 1;
  assign wrap    = (cnt == div_q - ONE);
  assign pass    = (div_q == ONE);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      state <= CG_IDLE;
      cnt   <= '0;
      div_q <= ONE;
      dc_q  <= 1'b0;
      out_q <= 1'b0;
    end else if (state == CG_IDLE) begin
      if (en_i) begin
        state <= CG_RUN;
        cnt   <= '0;
        div_q <= div_eff;
        dc_q  <= dc_i;
        out_q <= (div_eff > ONE);
      end
    end else if (nudge_i) begin
      cnt <= cnt;
    end else if (wrap) begin
      cnt <= '0;
      if (!en_i) begin
        state <= CG_IDLE;
        out_q <= 1'b0;
      end else begin
        div_q <= div_eff;
        dc_q  <= dc_i;
        out_q <= (div_eff > ONE);
      end
    end else begin
      cnt   <= cnt_nx;
      out_q <= (cnt_nx < half);
    end
  end

  always_ff @(negedge clk or negedge clr_n) begin
    if (!clr_n) begin
      out_n  <= 1'b0;
      gate_n <= 1'b0;
    end else begin
      out_n  <= out_q;
      gate_n <= (state == CG_RUN) && pass && (en_i || nudge_i) && (div_eff == ONE);
    end
  end

  assign clk_o    = pass ? (clk & gate_n) : (out_q | (dc_q & div_q[0] & out_n));
  assign active_o = (state == CG_RUN);
  assign cnt_o    = cnt;
  assign div_o    = div_q;
endmodule

// File: rtl/clkgen_top.sv
`timescale 1ns/1ps
module clkgen_top
  import clkgen_pkg::*;
#(
  parameter int unsigned NUM_SRC  = CG_NUM_SRC,
  parameter int unsigned SEL_W    = CG_SEL_W,
  parameter int unsigned DIV_W    = CG_DIV_W,
  parameter int unsigned PH_W     = CG_PH_W,
  parameter int unsigned SYNC_LEN = CG_SYNC_LEN
) (
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [DIV_W-1:0]   div_ratio,
  input  logic               run_en,
  input  logic               kill,
  input  logic [PH_W-1:0]    en_phase,
  input  logic               nudge,
  input  logic               duty_fix,
  output logic               clk_out,
  output logic               running
);
  logic             sel_clk;
  logic             clr_n;
  logic             en_sync;
  logic             en_dly;
  logic             nudge_sync;
  logic             nudge_last;
  logic             nudge_evt;
  logic             active;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_cur;

  assign clr_n = rst_n & ~kill;

  clkgen_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .src_i (src_clk),
    .sel_i (src_sel),
    .clk_o (sel_clk)
  );

  clkgen_sync #(.STAGES(SYNC_LEN)) u_en_sync (
    .clk   (sel_clk),
    .clr_n (clr_n),
    .d_i   (run_en),
    .q_o   (en_sync)
  );

  clkgen_sync #(.STAGES(SYNC_LEN)) u_nudge_sync (
    .clk   (sel_clk),
    .clr_n (clr_n),
    .d_i   (nudge),
    .q_o   (nudge_sync)
  );

  always_ff @(posedge sel_clk or negedge clr_n) begin
    if (!clr_n) nudge_last <= 1'b0;
    else        nudge_last <= nudge_sync;
  end

  assign nudge_evt = nudge_sync ^ nudge_last;

  clkgen_en_delay #(.PH_W(PH_W)) u_delay (
    .clk     (sel_clk),
    .clr_n   (clr_n),
    .en_i    (en_sync),
    .phase_i (en_phase),
    .busy_i  (active),
    .en_o    (en_dly)
  );

  clkgen_divider #(.DIV_W(DIV_W)) u_div (
    .clk      (sel_clk),
    .clr_n    (clr_n),
    .en_i     (en_dly),
    .nudge_i  (nudge_evt),
    .div_i    (div_ratio),
    .dc_i     (duty_fix),
    .active_o (active),
    .cnt_o    (div_cnt),
    .div_o    (div_cur),
    .clk_o    (clk_out)
  );

  assign running = active;
endmodule

// File: rtl/clkgen_chk.sv
`timescale 1ns/1ps
module clkgen_chk #(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned DIV_W   = 8
) (
  input logic             sel_clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             kill,
  input logic [SEL_W-1:0] src_sel,
  input logic             clk_out,
  input logic             running,
  input logic             nudge_evt,
  input logic [DIV_W-1:0] div_cnt,
  input logic [DIV_W-1:0] div_cur
);
  // R6
  stopped_low_chk: assert property (@(posedge sel_clk) disable iff (!clr_n)
    !running |-> !clk_out);

  // R7
  kill_quiet_chk: assert property (@(posedge sel_clk) disable iff (!rst_n)
    kill |-> (!running && !clk_out));

  // R8
  nudge_hold_chk: assert property (@(posedge sel_clk) disable iff (!clr_n)
    (running && nudge_evt) |=> $stable(div_cnt));

  // R3
  cnt_bound_chk: assert property (@(posedge sel_clk) disable iff (!clr_n)
    running |-> (div_cnt < div_cur));

  // R2
  always @(posedge clk_out) begin
    if (rst_n) begin
      no_src_rise_chk: assert (src_sel < SEL_W'(NUM_SRC));
    end
  end
endmodule

bind clkgen_top clkgen_chk #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_chk (
  .sel_clk   (sel_clk),
  .rst_n     (rst_n),
  .clr_n     (clr_n),
  .kill      (kill),
  .src_sel   (src_sel),
  .clk_out   (clk_out),
  .running   (running),
  .nudge_evt (nudge_evt),
  .div_cnt   (div_cnt),
  .div_cur   (div_cur)
);

// File: tb/clkgen_top_tb.sv
`timescale 1ns/1ps
module clkgen_top_tb;
  logic        clk = 1'b0;
  logic [10:0] src;
  logic        rst_n, run_en, kill, nudge, duty_fix;
  logic [3:0]  src_sel;
  logic [7:0]  div_ratio;
  logic [1:0]  en_phase;
  logic        clk_out, running;
  int          tests = 0;
  int          fails = 0;
  int          rises = 0;

  always #2.5 clk = ~clk;
  assign src[0] = clk;

  for (genvar gk = 1; gk < 11; gk++) begin : g_src
    logic c = 1'b0;
    always #(2.5 + gk) c = ~c;
    assign src[gk] = c;
  end

  always @(posedge clk_out) rises++;

  clkgen_top u_dut (
    .src_clk(src), .rst_n(rst_n), .src_sel(src_sel), .div_ratio(div_ratio),
    .run_en(run_en), .kill(kill), .en_phase(en_phase), .nudge(nudge),
    .duty_fix(duty_fix), .clk_out(clk_out), .running(running)
  );

  function automatic real src_per(int k);
    return 5.0 + 2.0 * k;
  endfunction

  function automatic real exp_per(int n, real p);
    return (n < 1) ? p : n * p;
  endfunction

  function automatic real exp_high(int n, bit dc, real p);
    if (n <= 1) return p / 2.0;
    return (n / 2) * p + ((dc && (n % 2 == 1)) ? p / 2.0 : 0.0);
  endfunction

  task automatic chk_real(string tag, real act, real exp);
    real d;
    tests++;
    d = act - exp;
    if (d < 0.0) d = -d;
    if (d > 0.05) begin
      fails++;
      $display("FAIL %s actual %0.3f expected %0.3f", tag, act, exp);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic measure(output real per, output real hi);
    real t0, t1, t2;
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic halt_wait();
    run_en = 1'b0;
    wait (!running);
    #30;
  endtask

  task automatic start_cfg(int k, int n, bit dc);
    halt_wait();
    src_sel = 4'(k); div_ratio = 8'(n); duty_fix = dc;
    #30;
    run_en = 1'b1;
    wait (running);
  endtask

  task automatic run_case(string tag, int k, int n, bit dc);
    real per, hi;
    start_cfg(k, n, dc);
    measure(per, hi);
    chk_real({tag, " period"}, per, exp_per(n, src_per(k)));
    chk_real({tag, " high"}, hi, exp_high(n, dc, src_per(k)));
  endtask

  task automatic latency(int p);
    int n;
    halt_wait();
    src_sel = 4'd0; div_ratio = 8'd4; duty_fix = 1'b0; en_phase = 2'(p);
    @(negedge clk); #1;
    run_en = 1'b1;
    n = 0;
    do begin
      @(posedge clk); #0.5;
      n++;
    end while (!running && n < 20);
    chk_int("R5 start latency", n, 3 + p);
    chk_int("R5 output high at start", int'(clk_out), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    real per, hi, t0, t1, t2;
    int  r0;
    void'($urandom(32'h1d5e_a7c3));
    rst_n = 1'b0; run_en = 1'b0; kill = 1'b0; nudge = 1'b0; duty_fix = 1'b0;
    src_sel = 4'd0; div_ratio = 8'd4; en_phase = 2'd0;
    #22;
    chk_int("R10 reset clk_out", int'(clk_out), 0);
    chk_int("R10 reset running", int'(running), 0);
    @(negedge clk); rst_n = 1'b1;

    // R5: start delay for each phase value
    latency(0);
    measure(per, hi);
    chk_real("R3 N=4 period", per, 20.0);
    chk_real("R3 N=4 high", hi, 10.0);
    latency(3);
    latency(1);

    // R6: clean stop in the middle of a high phase
    start_cfg(0, 6, 1'b0);
    @(posedge clk_out); t0 = $realtime; #1;
    run_en = 1'b0;
    @(negedge clk_out); t1 = $realtime;
    chk_real("R6 last pulse width", t1 - t0, 15.0);
    r0 = rises;
    repeat (30) @(posedge clk);
    #0.5;
    chk_int("R6 no rise after stop", rises, r0);
    chk_int("R6 running low", int'(running), 0);
    chk_int("R6 output low", int'(clk_out), 0);

    // R3 / R4 directed shapes
    run_case("R3 N=5", 0, 5, 1'b0);
    run_case("R4 N=5 dc", 0, 5, 1'b1);
    run_case("R4 N=4 dc no effect", 0, 4, 1'b1);
    run_case("R4 N=3 dc", 0, 3, 1'b1);
    run_case("R3 N=1", 0, 1, 1'b0);
    run_case("R3 N=0", 0, 0, 1'b0);

    // R9: divisor change mid-period
    start_cfg(0, 4, 1'b0);
    @(posedge clk_out); t0 = $realtime; #1;
    div_ratio = 8'd6;
    @(posedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    chk_real("R9 current period kept", t1 - t0, 20.0);
    chk_real("R9 next period new", t2 - t1, 30.0);

    // R8: nudge, rising then falling transition
    start_cfg(0, 6, 1'b0);
    for (int i = 0; i < 2; i++) begin
      @(posedge clk_out); t0 = $realtime; #1;
      nudge = ~nudge;
      @(posedge clk_out);
      @(posedge clk_out); t2 = $realtime;
      chk_real("R8 two periods after nudge", t2 - t0, 65.0);
    end
    measure(per, hi);
    chk_real("R8 period after slip", per, 30.0);

    // R7: asynchronous kill
    @(posedge clk_out); #1;
    kill = 1'b1;
    #0.2;
    chk_int("R7 output low at once", int'(clk_out), 0);
    chk_int("R7 running low at once", int'(running), 0);
    #40;
    chk_int("R7 output held low", int'(clk_out), 0);
    @(negedge clk); kill = 1'b0;
    repeat (10) @(posedge clk);
    #0.5;
    chk_int("R7 restart after release", int'(running), 1);

    // R2: invalid selections
    for (int s = 11; s < 16; s += 4) begin
      halt_wait();
      src_sel = 4'(s);
      r0 = rises;
      #10;
      run_en = 1'b1;
      #400;
      chk_int("R2 running stays low", int'(running), 0);
      chk_int("R2 no output edge", rises - r0, 0);
      chk_int("R2 output low", int'(clk_out), 0);
      run_en = 1'b0;
      #10;
      src_sel = 4'd0;
      #30;
    end

    // R1 with R3 and R4: seeded random sweep over sources
    for (int it = 0; it < 12; it++) begin
      int k, n;
      bit dc;
      k  = int'($urandom_range(10, 0));
      n  = int'($urandom_range(9, 1));
      dc = 1'($urandom_range(1, 0));
      run_case($sformatf("R1 src=%0d N=%0d dc=%0d", k, n, dc), k, n, dc);
    end

    halt_wait();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule